// File: doc/BRIEF.md
# Four-way instruction line cache

This block is a read-only instruction cache placed between a fetch unit and a memory read port. It holds 8 KiB as 256 slots of 256-bit lines, organised as 64 sets of four ways. A fetch request presents a byte address. The cache compares the upper address bits with the tags of the four ways in the indexed set and, on a hit, returns the whole 256-bit line. On a miss it issues a single-beat read for the line, installs the returned data in a chosen way, and then answers the fetch unit.

Only one memory transaction is in flight at a time. While a lookup or miss is pending, the fetch port is not ready. Each set keeps a 2-bit age per way. The replacement choice takes an empty way first; if the set is full, it takes the oldest way. A one-cycle flush command invalidates every line by sweeping the sets one per cycle, and the fetch port stalls until the sweep ends.

Top module: `fetch_line_cache`

## Requirements
- R1: After reset every line is invalid, `reqReady` is 1, and `rspValid` and `arValid` are 0.
- R2: The address splits into tag [31:11], set [10:5] and byte offset [4:0]. The offset does not select anything, because the whole line is returned. Addresses that differ only in bits [10:5] map to different sets.
- R3: A hit returns the stored line with `rspValid` high in the second cycle after the request is accepted, and issues no memory read.
- R4: A miss issues one read with `arAddr` equal to the request address with bits [4:0] cleared and `arId` equal to FILL_ID (default 0). The line from an OKAY beat (`rResp` = 2'b00) is installed and returned with `rspErr` = 0, and a later fetch of that line hits.
- R5: At most one transaction is outstanding. `reqReady` stays 0 from acceptance until the response. `arValid` and `arAddr` hold until `arReady`. No new read is issued before the data beat is taken.
- R6: When a set has an empty way, a miss fills the lowest-numbered empty way, so four distinct tags of one set can all be resident together.
- R7: Hits and fills make the accessed way the most recent, and ways that were more recent than it age by one. A miss in a full set replaces the least recent way.
- R8: A beat with `rResp` other than 2'b00 produces `rspValid` with `rspErr` = 1. No line is installed, and a later fetch of that address misses again.
- R9: A read data beat whose `rId` differs from FILL_ID is ignored. The cache keeps waiting for the matching beat.
- R10: `flushReq` high while idle takes priority over a request in that cycle, because `reqReady` is 0 while `flushReq` is 1. The flush holds `reqReady` at 0 for 64 cycles (one per set) and leaves every line invalid.
- R11: `rspValid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Fetch request valid |
| reqReady | output | 1 | Cache can accept a request this cycle |
| reqAddr | input | 32 | Fetch byte address |
| flushReq | input | 1 | Invalidate-all command, sampled while idle |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 256 | Returned line |
| rspErr | output | 1 | Response carries a failed fill |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address accepted |
| arAddr | output | 32 | Line-aligned read address |
| arId | output | 4 | Read transaction ID |
| rValid | input | 1 | Read data beat valid |
| rReady | output | 1 | Cache accepts a read data beat |
| rData | input | 256 | Read data line |
| rId | input | 4 | Read data transaction ID |
| rResp | input | 2 | Read response code, 2'b00 meaning OKAY |

## Verification
The assertions assume the memory side behaves as a single-beat read slave. It raises `arReady` only against a pending `arValid`. It returns data only after the address handshake. It offers a matching beat before another read is asked for. The bench's memory responder follows this order: it grants the address, optionally sends one stray-ID beat, then sends exactly one matching beat per read. It also pulses `flushReq` only while no fetch is in flight. The fetch stimulus waits for each response before making the next request, so the one-outstanding rule is never stressed from the fetch side.

// File: rtl/flc_pkg.sv
package flc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_ADDR,
    ST_DATA,
    ST_FLUSH
  } flcState_t;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic capture;     // latch the request address
    logic hitRead;     // load response from the array and refresh ages
    logic missLatch;   // latch the victim way
    logic fillWrite;   // install the fill line in the victim way
    logic fillDrop;    // failed fill: victim left invalid
    logic flushClear;  // clear valid bits of one set
  } flcStrobes_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/flc_datapath.sv
module flc_datapath
  import flc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256,
  parameter int WAYS   = 4,
  parameter int SETS   = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  flcStrobes_t              strb,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [$clog2(SETS)-1:0]  flushIdx,
  input  logic [LINE_W-1:0]        fillData,
  output logic                     lookupHit,
  output logic [ADDR_W-1:0]        missAddr,
  output logic [LINE_W-1:0]        rspData
);
  localparam int OFF_W = $clog2(LINE_W / 8);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tagQ;
  logic [IDX_W-1:0] idxQ;
  logic [WAY_W-1:0] victimQ;

  logic [SETS-1:0][WAYS-1:0] validQ;
  logic [WAY_W-1:0]  ageQ    [SETS][WAYS];
  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [LINE_W-1:0] dataMem [SETS*WAYS];

  logic [WAYS-1:0] hitVec, lruVec, invVec;
  logic [WAY_W-1:0] hitWay, lruWay, invWay, victimWay;
  logic [WAY_W-1:0] touchWay, touchAge;
  logic touchEn;

  logic unusedOffset;
  assign unusedOffset = ^reqAddr[OFF_W-1:0];

  // Per-way compare and status for the latched set.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = validQ[idxQ][w] && (tagMem[idxQ][w] == tagQ);
    assign lruVec[w] = (ageQ[idxQ][w] == WAY_W'(WAYS - 1));
    assign invVec[w] = !validQ[idxQ][w];
  end

  always_comb begin
    hitWay = '0;
    lruWay = '0;
    invWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (lruVec[w]) lruWay = WAY_W'(w);
      if (invVec[w]) invWay = WAY_W'(w);   // lowest index wins
    end
    victimWay = (|invVec) ? invWay : lruWay;
  end

  assign lookupHit = |hitVec;
  assign missAddr  = {tagQ, idxQ, {OFF_W{1'b0}}};

  assign touchEn  = strb.hitRead | strb.fillWrite;
  assign touchWay = strb.fillWrite ? victimQ : hitWay;
  assign touchAge = ageQ[idxQ][touchWay];

  // State with reset: valid bits, ages, request latch, response line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validQ[s][w] <= 1'b0;
          ageQ[s][w]   <= WAY_W'(w);
        end
      end
      tagQ    <= '0;
      idxQ    <= '0;
      victimQ <= '0;
      rspData <= '0;
    end else begin
      if (strb.capture) begin
        tagQ <= reqAddr[ADDR_W-1:OFF_W+IDX_W];
        idxQ <= reqAddr[OFF_W+IDX_W-1:OFF_W];
      end
      if (strb.missLatch) victimQ <= victimWay;
      if (strb.flushClear) validQ[flushIdx] <= '0;
      if (strb.fillWrite) begin
        validQ[idxQ][victimQ] <= 1'b1;
        rspData <= fillData;
      end
      if (strb.fillDrop) validQ[idxQ][victimQ] <= 1'b0;
      if (strb.hitRead) rspData <= dataMem[{idxQ, hitWay}];
      if (touchEn) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)          ageQ[idxQ][w] <= '0;
          else if (ageQ[idxQ][w] < touchAge)  ageQ[idxQ][w] <= ageQ[idxQ][w] + 1'b1;
        end
      end
    end
  end

  // Behavioural arrays, no reset.
  always_ff @(posedge clk) begin
    if (strb.fillWrite) begin
      tagMem[idxQ][victimQ]       <= tagQ;
      dataMem[{idxQ, victimQ}]    <= fillData;
    end
  end

  // R7: the ages of a set always form an ordering with a single oldest way.
  a_r7_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lruVec) == 1);

  // R2: one tag is never resident in two ways of the same set.
  a_r2_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec));

  // R4: right after a fill the same line hits.
  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fillWrite |=> lookupHit);

  // R8: a failed fill leaves the line absent.
  a_r8_drop_absent: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fillDrop |=> !lookupHit);

endmodule

// File: rtl/flc_ctrl.sv
module flc_ctrl
  import flc_pkg::*;
#(
  parameter int SETS = 64,
  parameter int ID_W = 4,
  parameter logic [ID_W-1:0] FILL_ID = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic                     flushReq,
  input  logic                     lookupHit,
  output logic                     rspValid,
  output logic                     rspErr,
  output logic                     arValid,
  input  logic                     arReady,
  output logic [ID_W-1:0]          arId,
  input  logic                     rValid,
  output logic                     rReady,
  input  logic [ID_W-1:0]          rId,
  input  logic [1:0]               rResp,
  output flcStrobes_t              strb,
  output logic [$clog2(SETS)-1:0]  flushIdx
);
  localparam int IDX_W = $clog2(SETS);

  flcState_t state, nextState;
  logic [IDX_W-1:0] flushCnt;
  logic beatOk;

  assign arId     = FILL_ID;
  assign flushIdx = flushCnt;
  assign beatOk   = rValid && (rId == FILL_ID);

  always_comb begin
    strb      = '0;
    nextState = state;
    reqReady  = (state == ST_IDLE) && !flushReq;
    arValid   = (state == ST_ADDR);
    rReady    = (state == ST_DATA);
    case (state)
      ST_IDLE: begin
        if (flushReq) begin
          nextState = ST_FLUSH;
        end else if (reqValid) begin
          strb.capture = 1'b1;
          nextState    = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lookupHit) begin
          strb.hitRead = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          strb.missLatch = 1'b1;
          nextState      = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (arReady) nextState = ST_DATA;
      end
      ST_DATA: begin
        if (beatOk) begin
          if (rResp == RESP_OKAY) strb.fillWrite = 1'b1;
          else                    strb.fillDrop  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        strb.flushClear = 1'b1;
        if (flushCnt == IDX_W'(SETS - 1)) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      flushCnt <= '0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      state    <= nextState;
      flushCnt <= (state == ST_FLUSH) ? flushCnt + 1'b1 : '0;
      rspValid <= strb.hitRead | strb.fillWrite | strb.fillDrop;
      rspErr   <= strb.fillDrop;
    end
  end

  // R5: a pending read address is held until taken.
  a_r5_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arValid && !arReady |=> arValid);

  // R5: once a read address is taken, no second one follows immediately.
  a_r5_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    arValid && arReady |=> !arValid);

  // R11: responses are single-cycle pulses.
  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R5: the fetch port is closed in the cycle after a request is taken.
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);

endmodule

// File: rtl/fetch_line_cache.sv
module fetch_line_cache
  import flc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256,
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int ID_W   = 4,
  parameter logic [ID_W-1:0] FILL_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              flushReq,
  output logic              rspValid,
  output logic [LINE_W-1:0] rspData,
  output logic              rspErr,
  output logic              arValid,
  input  logic              arReady,
  output logic [ADDR_W-1:0] arAddr,
  output logic [ID_W-1:0]   arId,
  input  logic              rValid,
  output logic              rReady,
  input  logic [LINE_W-1:0] rData,
  input  logic [ID_W-1:0]   rId,
  input  logic [1:0]        rResp
);
  localparam int IDX_W = $clog2(SETS);

  flcStrobes_t      strb;
  logic             lookupHit;
  logic [IDX_W-1:0] flushIdx;

  flc_ctrl #(.SETS(SETS), .ID_W(ID_W), .FILL_ID(FILL_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .flushReq(flushReq),
    .lookupHit(lookupHit), .rspValid(rspValid), .rspErr(rspErr),
    .arValid(arValid), .arReady(arReady), .arId(arId),
    .rValid(rValid), .rReady(rReady), .rId(rId), .rResp(rResp),
    .strb(strb), .flushIdx(flushIdx)
  );

  flc_datapath #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .WAYS(WAYS), .SETS(SETS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqAddr(reqAddr),
    .flushIdx(flushIdx), .fillData(rData), .lookupHit(lookupHit),
    .missAddr(arAddr), .rspData(rspData)
  );

  // R5: the read address does not move while it waits for acceptance.
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    arValid && !arReady |=> $stable(arAddr));

endmodule

// File: tb/fetch_line_cache_bench.sv
module fetch_line_cache_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqAddr = '0;
  logic flushReq = 1'b0;
  logic rspValid;
  logic [255:0] rspData;
  logic rspErr;
  logic arValid;
  logic arReady;
  logic [31:0] arAddr;
  logic [3:0] arId;
  logic rValid;
  logic rReady;
  logic [255:0] rData;
  logic [3:0] rId;
  logic [1:0] rResp;

  int checks = 0;
  int fails = 0;
  int arCount = 0;
  logic [31:0] lastArAddr = '0;
  logic [3:0] lastArId = '0;
  logic [31:0] salt = 32'h0BADF00D;
  bit injErr = 0;
  bit injStray = 0;

  always #10 clk = ~clk;   // 20 ns period, 50 MHz

  fetch_line_cache u_fetch_line_cache (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .flushReq(flushReq), .rspValid(rspValid),
    .rspData(rspData), .rspErr(rspErr), .arValid(arValid), .arReady(arReady),
    .arAddr(arAddr), .arId(arId), .rValid(rValid), .rReady(rReady),
    .rData(rData), .rId(rId), .rResp(rResp)
  );

  function automatic logic [255:0] lineOf(input logic [31:0] a, input logic [31:0] s);
    logic [255:0] v;
    for (int i = 0; i < 8; i++)
      v[i*32 +: 32] = {a[31:5], 5'b0} ^ (32'(i) * 32'h01010101) ^ s;
    return v;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  // Memory responder: single-beat reads.
  initial begin
    arReady = 1'b0; rValid = 1'b0; rData = '0; rId = '0; rResp = 2'b00;
    forever begin
      @(negedge clk);
      if (arValid) begin
        lastArAddr = arAddr;
        lastArId   = arId;
        arReady    = 1'b1;
        @(negedge clk);
        arReady = 1'b0;
        arCount++;
        if (injStray) begin
          rValid = 1'b1; rId = lastArId ^ 4'h1; rResp = 2'b00; rData = '1;
          @(negedge clk);
        end
        rValid = 1'b1;
        rId    = lastArId;
        rResp  = injErr ? 2'b10 : 2'b00;
        rData  = lineOf(lastArAddr, salt);
        @(negedge clk);
        rValid = 1'b0;
      end
    end
  end

  task automatic doFetch(input logic [31:0] a, input logic [255:0] expData,
                         input bit expMiss, input bit expErr, input string rq);
    int c0 = arCount;
    int lat = 0;
    bit readySeen = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 1000) begin
      if (reqReady) readySeen = 1;
      @(negedge clk);
      lat++;
    end
    chk(rspValid, rq, "response arrived", 256'(rspValid), 256'(1));
    chk((arCount - c0) == int'(expMiss), rq, "memory reads issued",
        256'(arCount - c0), 256'(expMiss));
    chk(rspErr == expErr, rq, "rspErr", 256'(rspErr), 256'(expErr));
    if (!expErr) chk(rspData == expData, rq, "line data", rspData, expData);
    if (expMiss) begin
      chk(lastArAddr == {a[31:5], 5'b0}, "R4", "read address",
          256'(lastArAddr), 256'({a[31:5], 5'b0}));
      chk(lastArId == 4'h0, "R4", "read id", 256'(lastArId), 256'(0));
      chk(!readySeen, "R5", "reqReady stayed low during miss", 256'(readySeen), 256'(0));
    end else begin
      chk(lat == 2, "R3", "hit latency", 256'(lat), 256'(2));
    end
    @(negedge clk);
    chk(!rspValid, "R11", "single-cycle response", 256'(rspValid), 256'(0));
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", 256'(reqReady), 256'(1));
    chk(rspValid == 1'b0, "R1", "rspValid after reset", 256'(rspValid), 256'(0));
    chk(arValid == 1'b0, "R1", "arValid after reset", 256'(arValid), 256'(0));
  endtask

  task automatic testHitMiss();
    logic [31:0] x = 32'h0001_2344;
    logic [255:0] oldLine = lineOf(x, salt);
    doFetch(x, oldLine, 1, 0, "R4");
    salt = 32'h5EED_1234;
    // R3 and R2: same line, other offset, returns the stored (old) data
    doFetch(x | 32'h1B, oldLine, 0, 0, "R3");
    // R2: flipping set bit 5 selects another set
    doFetch(x ^ 32'h20, lineOf(x ^ 32'h20, salt), 1, 0, "R2");
  endtask

  task automatic testReplace();
    logic [31:0] a[6];
    for (int t = 1; t <= 5; t++) a[t] = (32'(t) << 11) | 32'h60;
    for (int t = 1; t <= 4; t++) doFetch(a[t], lineOf(a[t], salt), 1, 0, "R6");
    for (int t = 1; t <= 4; t++) doFetch(a[t], lineOf(a[t], salt), 0, 0, "R6");
    doFetch(a[1], lineOf(a[1], salt), 0, 0, "R7");   // 1 newest, 2 oldest
    doFetch(a[5], lineOf(a[5], salt), 1, 0, "R7");   // evicts 2
    doFetch(a[1], lineOf(a[1], salt), 0, 0, "R7");
    doFetch(a[3], lineOf(a[3], salt), 0, 0, "R7");
    doFetch(a[4], lineOf(a[4], salt), 0, 0, "R7");   // order 4,3,1,5
    doFetch(a[2], lineOf(a[2], salt), 1, 0, "R7");   // evicts 5
    doFetch(a[5], lineOf(a[5], salt), 1, 0, "R7");   // evicts 1
    doFetch(a[4], lineOf(a[4], salt), 0, 0, "R7");
    doFetch(a[1], lineOf(a[1], salt), 1, 0, "R7");
  endtask

  task automatic testErrors();
    logic [31:0] g = 32'h00AB_C120;
    logic [31:0] h = 32'h0077_0140;
    injErr = 1;
    doFetch(g, '0, 1, 1, "R8");
    injErr = 0;
    doFetch(g, lineOf(g, salt), 1, 0, "R8");
    injStray = 1;
    doFetch(h, lineOf(h, salt), 1, 0, "R9");
    injStray = 0;
    doFetch(h, lineOf(h, salt), 0, 0, "R9");
  endtask

  task automatic testFlush();
    logic [31:0] x = 32'h0001_2344;
    int lowCycles = 0;
    int c0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = x; flushReq = 1'b1;
    #1;
    chk(reqReady == 1'b0, "R10", "flush outranks request", 256'(reqReady), 256'(0));
    @(negedge clk);
    flushReq = 1'b0;
    c0 = arCount;
    while (!reqReady && lowCycles < 1000) begin
      lowCycles++;
      @(negedge clk);
    end
    chk(lowCycles == 64, "R10", "flush stall cycles", 256'(lowCycles), 256'(64));
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid && lowCycles < 2000) begin
      lowCycles++;
      @(negedge clk);
    end
    chk((arCount - c0) == 1, "R10", "flushed line refetched", 256'(arCount - c0), 256'(1));
    chk(rspData == lineOf(x, salt), "R10", "refetched data", rspData, lineOf(x, salt));
    doFetch(x, lineOf(x, salt), 0, 0, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testHitMiss();
    testReplace();
    testErrors();
    testFlush();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule